// File: doc/BRIEF.md
# SMBus Register-Access Target

This block connects a small internal register file to a two-wire SMBus as a target device. It oversamples SCL and SDA with the system clock. Both lines pass through a synchronizer and a glitch filter. The block then detects start and stop conditions and frames the bus into nine-clock byte slots: eight data bits, most significant bit first, then one acknowledge bit. It drives SDA only in open-drain fashion, through a single pull-low enable.

The 7-bit target address is chosen by two strap inputs and frozen at the first address byte that matches. A write transaction carries one or two data bytes. The first byte always loads an internal pointer. A second byte is written to the register that the pointer selects, using a one-cycle strobe. A read transaction returns exactly one byte, taken from the pointed register. Toward the inside the block offers a plain register port: address (the pointer), write data, write strobe and read data. The read data is taken combinationally from the surrounding register file.

Top module: `smb_regport_target`

## Requirements
- R1: With `strap_fixed` high the target address is 7'h2E. With `strap_fixed` low, `strap_pick` low selects 7'h2C and `strap_pick` high selects 7'h2D. A matching address byte (address in bits 7..1, R/W in bit 0) is acknowledged: SDA is held low through the 9th SCL high period.
- R2: The address in force is frozen when the first matching address byte completes. After that, strap changes have no effect until reset.
- R3: After a non-matching address byte the block gives no acknowledge, keeps SDA released and issues no write strobe until the next start or stop.
- R4: A write carrying a single data byte loads that byte into the pointer (`reg_addr`) and issues no write strobe.
- R5: In a write, the second data byte produces exactly one `reg_we` pulse, one clock long, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The address byte and both data bytes are acknowledged.
- R6: A third data byte in a write is not acknowledged and causes no write strobe.
- R7: A read (R/W = 1) shifts out `reg_rdata` for the current pointer, MSB first, with each bit stable over its SCL high period. No pointer write is needed beforehand. After that byte, SDA stays released.
- R8: A repeated start, even in the middle of a byte, returns the block to address reception with the bit count cleared. The pointer is kept.
- R9: After reset `sda_oe`, `reg_we` and `reg_addr` are 0. `sda_oe` only rises while the filtered SCL is low, and a stop releases it.
- R10: A pulse shorter than `FILT_LEN` system clocks on either line has no effect on framing, so it cannot act as a false start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad (wired level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_fixed | input | 1 | Address strap: 1 picks the fixed address |
| strap_pick | input | 1 | Address select when `strap_fixed` is 0 |
| reg_addr | output | 8 | Pointer, used as the register-file address |
| reg_wdata | output | 8 | Data for a register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register-file data at `reg_addr` |

## Verification
The assertions assume the host changes SDA only while SCL is low. They also assume every SCL high and low phase lasts longer than the synchronizer plus filter latency, and that the host never starts a condition while the target is pulling SDA low. The bench holds each quarter bit for 12 system clocks, which is well above the six-clock input latency. It changes SDA only during the low phase, except for the deliberate start, stop and two-clock glitch stimulus. That glitch is kept below `FILT_LEN` so it stays inside the filtered contract.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int BIT_CNT_W = 4;
    localparam logic [BIT_CNT_W-1:0] LAST_DATA_BIT = 4'd7;
    localparam logic [BIT_CNT_W-1:0] ACK_SLOT = 4'd8;

    localparam logic [ADDR_W-1:0] ADDR_FIXED  = 7'h2E;
    localparam logic [ADDR_W-1:0] ADDR_PICK_0 = 7'h2C;
    localparam logic [ADDR_W-1:0] ADDR_PICK_1 = 7'h2D;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_TX,
        ST_SKIP
    } smbt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } smbt_evt_t;

    function automatic logic [ADDR_W-1:0] strap_addr(input logic fixed, input logic pick);
        if (fixed) begin
            return ADDR_FIXED;
        end
        return pick ? ADDR_PICK_1 : ADDR_PICK_0;
    endfunction

endpackage

// File: rtl/smbt_line_filter.sv
module smbt_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       stable_cnt;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
        end
    end

    // Output follows the synchronized line only after FILT_LEN equal samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            clean      <= 1'b1;
            stable_cnt <= '0;
        end else if (synced != clean) begin
            if (stable_cnt == CNT_LAST) begin
                clean      <= synced;
                stable_cnt <= '0;
            end else begin
                stable_cnt <= stable_cnt + 1'b1;
            end
        end else begin
            stable_cnt <= '0;
        end
    end

endmodule

// File: rtl/smbt_cond_detect.sv
module smbt_cond_detect
    import smbt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl,
    input  logic      sda,
    output smbt_evt_t evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        evt.scl_rise = scl & ~scl_q;
        evt.scl_fall = ~scl & scl_q;
        evt.start    = scl & scl_q & sda_q & ~sda;
        evt.stop     = scl & scl_q & ~sda_q & sda;
        evt.sda      = sda;
    end

endmodule

// File: rtl/smbt_addr_lock.sv
module smbt_addr_lock
    import smbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_fixed,
    input  logic              strap_pick,
    input  logic              lock_req,
    input  logic [ADDR_W-1:0] lock_val,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              locked
);
    logic [ADDR_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            held   <= '0;
        end else if (lock_req && !locked) begin
            locked <= 1'b1;
            held   <= lock_val;
        end
    end

    assign cur_addr = locked ? held : strap_addr(strap_fixed, strap_pick);

endmodule

// File: rtl/smbt_engine.sv
module smbt_engine
    import smbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  smbt_evt_t         evt,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              lock_req,
    output logic [ADDR_W-1:0] lock_val,
    output logic [DATA_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              sda_drive,
    output smbt_state_e       state_o
);
    smbt_state_e          st;
    logic [BIT_CNT_W-1:0] bitcnt;
    logic [DATA_W-2:0]    shreg;
    logic [DATA_W-2:0]    tx_sh;
    logic [1:0]           byte_idx;
    logic                 rw;
    logic                 frame_done;
    logic                 ack_want;
    logic                 in_frame;
    logic [DATA_W-1:0]    in_byte;

    assign in_frame = (st == ST_ADDR) || (st == ST_RX) || (st == ST_TX);
    assign in_byte  = {shreg, evt.sda};
    assign state_o  = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            tx_sh      <= '0;
            byte_idx   <= '0;
            rw         <= 1'b0;
            frame_done <= 1'b0;
            ack_want   <= 1'b0;
            sda_drive  <= 1'b0;
            reg_addr   <= '0;
            reg_wdata  <= '0;
            reg_we     <= 1'b0;
            lock_req   <= 1'b0;
            lock_val   <= '0;
        end else begin
            reg_we   <= 1'b0;
            lock_req <= 1'b0;
            if (evt.start) begin
                st         <= ST_ADDR;
                bitcnt     <= '0;
                byte_idx   <= '0;
                frame_done <= 1'b0;
                ack_want   <= 1'b0;
                sda_drive  <= 1'b0;
            end else if (evt.stop) begin
                st         <= ST_IDLE;
                bitcnt     <= '0;
                frame_done <= 1'b0;
                ack_want   <= 1'b0;
                sda_drive  <= 1'b0;
            end else if (evt.scl_rise && in_frame) begin
                if (bitcnt == ACK_SLOT) begin
                    // Ninth clock: frame closes, pick what follows.
                    bitcnt     <= '0;
                    frame_done <= 1'b1;
                    if (st == ST_ADDR) begin
                        st <= rw ? ST_TX : ST_RX;
                    end else if (st == ST_TX) begin
                        st <= ST_SKIP;
                    end
                end else begin
                    shreg      <= in_byte[DATA_W-2:0];
                    bitcnt     <= bitcnt + 1'b1;
                    frame_done <= 1'b0;
                    if (bitcnt == LAST_DATA_BIT) begin
                        unique case (st)
                            ST_ADDR: begin
                                if (shreg == cur_addr) begin
                                    rw       <= evt.sda;
                                    ack_want <= 1'b1;
                                    lock_req <= 1'b1;
                                    lock_val <= shreg;
                                end else begin
                                    ack_want <= 1'b0;
                                    st       <= ST_SKIP;
                                end
                            end
                            ST_RX: begin
                                if (byte_idx == 2'd0) begin
                                    reg_addr <= in_byte;
                                    ack_want <= 1'b1;
                                    byte_idx <= 2'd1;
                                end else if (byte_idx == 2'd1) begin
                                    reg_wdata <= in_byte;
                                    reg_we    <= 1'b1;
                                    ack_want  <= 1'b1;
                                    byte_idx  <= 2'd2;
                                end else begin
                                    ack_want <= 1'b0;
                                    st       <= ST_SKIP;
                                end
                            end
                            default: ack_want <= 1'b0;
                        endcase
                    end
                end
            end else if (evt.scl_fall) begin
                if (!in_frame) begin
                    sda_drive <= 1'b0;
                end else if (bitcnt == ACK_SLOT) begin
                    sda_drive <= ack_want && (st != ST_TX);
                end else if (frame_done) begin
                    frame_done <= 1'b0;
                    if (st == ST_TX) begin
                        tx_sh     <= reg_rdata[DATA_W-2:0];
                        sda_drive <= ~reg_rdata[DATA_W-1];
                    end else begin
                        sda_drive <= 1'b0;
                    end
                end else if (st == ST_TX && bitcnt != '0) begin
                    sda_drive <= ~tx_sh[DATA_W-2];
                    tx_sh     <= {tx_sh[DATA_W-3:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/smb_regport_target.sv
module smb_regport_target
    import smbt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              strap_fixed,
    input  logic              strap_pick,
    output logic [DATA_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    logic               scl_filt;
    logic               sda_filt;
    smbt_evt_t          evt;
    logic               stop_seen;
    logic               lock_req;
    logic [ADDR_W-1:0]  lock_val;
    logic [ADDR_W-1:0]  cur_addr;
    logic               addr_locked;
    smbt_state_e        eng_state;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        smbt_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_lines[g]),
            .clean(clean_lines[g])
        );
    end

    assign scl_filt = clean_lines[0];
    assign sda_filt = clean_lines[1];

    smbt_cond_detect u_cond (
        .clk(clk),
        .rst(rst),
        .scl(scl_filt),
        .sda(sda_filt),
        .evt(evt)
    );

    assign stop_seen = evt.stop;

    smbt_addr_lock u_lock (
        .clk        (clk),
        .rst        (rst),
        .strap_fixed(strap_fixed),
        .strap_pick (strap_pick),
        .lock_req   (lock_req),
        .lock_val   (lock_val),
        .cur_addr   (cur_addr),
        .locked     (addr_locked)
    );

    smbt_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .cur_addr (cur_addr),
        .lock_req (lock_req),
        .lock_val (lock_val),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_rdata(reg_rdata),
        .sda_drive(sda_oe),
        .state_o  (eng_state)
    );

endmodule

// File: rtl/smbt_checker.sv
module smbt_checker
    import smbt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              reg_we,
    input logic              scl_f,
    input logic              stop_ev,
    input logic              locked,
    input logic [ADDR_W-1:0] held_addr,
    input smbt_state_e       state
);

    assert_oe_rises_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_f);

    assert_stop_releases_R9: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_oe);

    assert_we_single_R5: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    assert_lock_stable_R2: assert property (@(posedge clk) disable iff (rst)
        locked |=> (locked && $stable(held_addr)));

    assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> !sda_oe);

    assert_skip_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |=> !reg_we);

endmodule

bind smb_regport_target smbt_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .scl_f    (scl_filt),
    .stop_ev  (stop_seen),
    .locked   (addr_locked),
    .held_addr(cur_addr),
    .state    (eng_state)
);

// File: tb/tb_smb_regport_target.sv
module tb_smb_regport_target;

    localparam int Q = 12;
    localparam int N_VEC = 6;
    // {pointer, data}
    localparam logic [15:0] VEC [N_VEC] = '{
        16'h103C, 16'h00FF, 16'hFF00, 16'h7FA5, 16'h805A, 16'h10C3
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst;
    logic       host_scl;
    logic       host_sda;
    logic       strap_fixed;
    logic       strap_pick;
    logic       sda_oe;
    logic       reg_we;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       sda_line;
    logic [7:0] mem [256];

    int         n_cmp = 0;
    int         n_bad = 0;
    int         we_cnt = 0;
    logic [7:0] last_wa = '0;
    logic [7:0] last_wd = '0;
    bit         finished = 1'b0;

    assign sda_line  = host_sda & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    smb_regport_target dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (host_scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .strap_fixed(strap_fixed),
        .strap_pick (strap_pick),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .reg_rdata  (reg_rdata)
    );

    always @(negedge clk) begin
        if (!rst && reg_we) begin
            we_cnt++;
            last_wa = reg_addr;
            last_wd = reg_wdata;
            mem[reg_addr] = reg_wdata;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; wait_clk(Q);
        host_scl = 1'b1; wait_clk(Q);
        host_sda = 1'b0; wait_clk(Q);
        host_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wait_clk(Q);
        host_scl = 1'b1; wait_clk(Q);
        host_sda = 1'b1; wait_clk(2 * Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        host_sda = b; wait_clk(Q);
        host_scl = 1'b1;
        if (glitch) begin
            wait_clk(Q - 2);
            host_sda = ~b; wait_clk(2);
            host_sda = b;  wait_clk(Q);
        end else begin
            wait_clk(2 * Q);
        end
        host_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic recv_bit(output logic b);
        host_sda = 1'b1; wait_clk(Q);
        host_scl = 1'b1; wait_clk(Q);
        b = sda_line;    wait_clk(Q);
        host_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit glitch, output bit acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i], glitch);
        recv_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(1'b1, 1'b0);
    endtask

    task automatic wr_ptr(input logic [6:0] a, input logic [7:0] p, output bit aa, output bit pa);
        bus_start();
        send_byte({a, 1'b0}, 1'b0, aa);
        send_byte(p, 1'b0, pa);
        bus_stop();
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                          output bit aa, output bit pa, output bit da);
        bus_start();
        send_byte({a, 1'b0}, 1'b0, aa);
        send_byte(p, 1'b0, pa);
        send_byte(d, 1'b0, da);
        bus_stop();
    endtask

    task automatic rd_reg(input logic [6:0] a, output logic [7:0] v, output bit aa);
        bus_start();
        send_byte({a, 1'b1}, 1'b0, aa);
        recv_byte(v);
        bus_stop();
    endtask

    task automatic do_reset(input logic fx, input logic pk);
        rst = 1'b1;
        host_scl = 1'b1;
        host_sda = 1'b1;
        strap_fixed = fx;
        strap_pick = pk;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(Q);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        bit aa, pa, da, xa;
        logic [7:0] rv;
        int wc;

        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;

        do_reset(1'b1, 1'b0);
        chk("R9 reset sda_oe", sda_oe, 0);
        chk("R9 reset reg_we", reg_we, 0);
        chk("R9 reset reg_addr", reg_addr, 0);

        // Table walk: write, re-point, read back.
        for (int i = 0; i < N_VEC; i++) begin
            wc = we_cnt;
            wr_reg(7'h2E, VEC[i][15:8], VEC[i][7:0], aa, pa, da);
            chk("R1 addr ack 0x2E", aa, 1);
            chk("R5 ptr ack", pa, 1);
            chk("R5 data ack", da, 1);
            chk("R5 one strobe", we_cnt, wc + 1);
            chk("R5 strobe addr", last_wa, VEC[i][15:8]);
            chk("R5 strobe data", last_wd, VEC[i][7:0]);
            wr_ptr(7'h2E, VEC[i][15:8] ^ 8'h01, aa, pa);
            chk("R4 ptr only loads", reg_addr, VEC[i][15:8] ^ 8'h01);
            chk("R4 no strobe", we_cnt, wc + 1);
            wr_ptr(7'h2E, VEC[i][15:8], aa, pa);
            rd_reg(7'h2E, rv, aa);
            chk("R7 read ack", aa, 1);
            chk("R7 read data", rv, VEC[i][7:0]);
            chk("R9 released after read", sda_oe, 0);
        end

        // Read without pointer write: pointer still 0x10.
        rd_reg(7'h2E, rv, aa);
        chk("R7 read w/o pointer write", rv, 8'hC3);

        // Third data byte.
        wc = we_cnt;
        bus_start();
        send_byte({7'h2E, 1'b0}, 1'b0, aa);
        send_byte(8'h20, 1'b0, pa);
        send_byte(8'h11, 1'b0, da);
        send_byte(8'h22, 1'b0, xa);
        bus_stop();
        chk("R6 third byte nacked", xa, 0);
        chk("R6 single strobe", we_cnt, wc + 1);
        chk("R6 stored second byte", mem[8'h20], 8'h11);

        // Non-matching address.
        wc = we_cnt;
        bus_start();
        send_byte({7'h2C, 1'b0}, 1'b0, aa);
        send_byte(8'h55, 1'b0, pa);
        send_byte(8'h66, 1'b0, da);
        chk("R3 addr nacked", aa, 0);
        chk("R3 data nacked", pa, 0);
        chk("R3 sda released", sda_oe, 0);
        bus_stop();
        chk("R3 no strobe", we_cnt, wc);
        chk("R3 pointer kept", reg_addr, 8'h20);

        // Repeated start after pointer byte, then read.
        bus_start();
        send_byte({7'h2E, 1'b0}, 1'b0, aa);
        send_byte(8'h7F, 1'b0, pa);
        bus_start();
        send_byte({7'h2E, 1'b1}, 1'b0, aa);
        recv_byte(rv);
        bus_stop();
        chk("R8 read after repeated start", rv, 8'hA5);
        chk("R8 addr ack after repeated start", aa, 1);

        // Repeated start in the middle of a byte.
        bus_start();
        send_byte({7'h2E, 1'b0}, 1'b0, aa);
        for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
        bus_start();
        send_byte({7'h2E, 1'b1}, 1'b0, aa);
        recv_byte(rv);
        bus_stop();
        chk("R8 mid-byte restart ack", aa, 1);
        chk("R8 mid-byte restart data", rv, 8'hA5);
        chk("R8 pointer kept", reg_addr, 8'h7F);

        // Short glitches on SDA during SCL high.
        wc = we_cnt;
        bus_start();
        send_byte({7'h2E, 1'b0}, 1'b1, aa);
        send_byte(8'h40, 1'b1, pa);
        send_byte(8'h99, 1'b1, da);
        bus_stop();
        chk("R10 glitch addr ack", aa, 1);
        chk("R10 glitch strobe", we_cnt, wc + 1);
        chk("R10 glitch waddr", last_wa, 8'h40);
        chk("R10 glitch wdata", last_wd, 8'h99);

        // Strap selection and freezing.
        do_reset(1'b0, 1'b0);
        strap_pick = 1'b1;
        wait_clk(Q);
        wr_ptr(7'h2D, 8'h01, aa, pa);
        chk("R1 pick high gives 0x2D", aa, 1);
        strap_pick = 1'b0;
        wait_clk(Q);
        wr_ptr(7'h2C, 8'h02, aa, pa);
        chk("R2 frozen, 0x2C nacked", aa, 0);
        strap_fixed = 1'b1;
        wait_clk(Q);
        wr_ptr(7'h2E, 8'h03, aa, pa);
        chk("R2 frozen, 0x2E nacked", aa, 0);
        wr_ptr(7'h2D, 8'h04, aa, pa);
        chk("R2 frozen address acked", aa, 1);
        chk("R2 pointer via frozen addr", reg_addr, 8'h04);

        do_reset(1'b0, 1'b0);
        wr_ptr(7'h2E, 8'h05, aa, pa);
        chk("R1 0x2E nacked when strap low", aa, 0);
        wr_ptr(7'h2C, 8'h06, aa, pa);
        chk("R1 pick low gives 0x2C", aa, 1);

        finished = 1'b1;
        report();
    end

endmodule